// File: doc/BRIEF.md
# Shared-Port Memory Read Steering

This block carries a 72-bit read doubleword from memory to a processor's 36-bit internal bus. Each 36-bit word holds 32 data bits and 4 parity bits. The doubleword comes from one of three sources: internal memory, an external memory cabinet, or an add-on memory.

The path has four stages:
- A first multiplexer picks internal or external memory under an active-low gate-internal control.
- A 72-bit capture register loads the chosen doubleword while an open-window enable is high.
- An active-low select-even control picks one of the two words held in the register.
- A final multiplexer picks either that word or the latched ALU result to drive the bus.

The add-on memory needs no extra wiring to the host's steering. It always presents its data on the odd-word lanes. When it is the selected memory, it forces all three steering controls high through the storage-2 and storage-3 cycles of an access. The forcing is modelled as an OR with the host's own values, because only a high level can be imposed on the shared control wires. On the odd lanes, a port-sharing multiplexer replaces the external odd word with the add-on word only when all three effective controls are high. The bus word's parity is checked as it leaves the block.

Top module: `shared_port_steer`

## Requirements
- R1: A synchronous active-low reset clears the capture register to zero. After reset, the bus shows 0000_0000_0 with parity error low whenever the ALU path is not selected.
- R2: In a cycle where the effective window is high, the register loads internal memory if the effective gate-internal control is low. It loads the external doubleword if that control is high.
- R3: While the effective window is low, the capture register keeps its contents.
- R4: The even word is bits 71:36 and the odd word is bits 35:0. The bus shows the even word when the effective select-even control is low and the odd word when it is high.
- R5: When bus_sel_alu is high, the bus equals alu_d whatever the capture register holds.
- R6: When addon_sel is high together with stor2 or stor3, all three effective controls are high. In every other cycle, each effective control equals its host input.
- R7: When addon_sel is high and all three effective controls are high, the odd lanes of the register load addon_odd and the even lanes load the external even word.
- R8: When addon_sel is low, addon_odd has no effect, even with all three host controls high. The odd lanes then load the external odd word.
- R9: Within a word, bits 31:0 are data and bit 32+i is the even-parity bit of byte i (bits 8i+7:8i). par_err is high exactly when some byte of the bus word disagrees with its parity bit.
- R10: On a storage-3 cycle with addon_sel high, the register loads the add-on access even if the host holds its window low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| int_dw | input | 72 | Internal memory doubleword |
| ext_dw | input | 72 | External cabinet doubleword |
| addon_odd | input | 36 | Add-on memory word, odd lanes only |
| alu_d | input | 36 | Latched ALU result |
| host_gate_int_n | input | 1 | Host gate-internal control, active low |
| host_clk_win | input | 1 | Host capture window enable |
| host_sel_even_n | input | 1 | Host select-even control, active low |
| addon_sel | input | 1 | Add-on memory is the selected memory |
| stor2 | input | 1 | Storage-2 cycle |
| stor3 | input | 1 | Storage-3 cycle |
| bus_sel_alu | input | 1 | Drive the ALU result onto the bus |
| bus_out | output | 36 | Internal bus word |
| par_err | output | 1 | Parity mismatch on the bus word |
| gate_int_n_eff | output | 1 | Effective gate-internal control |
| clk_win_eff | output | 1 | Effective capture window |
| sel_even_n_eff | output | 1 | Effective select-even control |

## Verification
A wrong force term shows on the effective control outputs in the same cycle. A wrong source select or a missed add-on load shows up later, when the word is read. The register corrupts in that clock, and the wrong data reaches the bus in the next read cycle, or reaches it with par_err raised. A register that reloads while its window is low shows as changed data at the next read after that cycle. Every read is compared with a reference doubleword kept in the bench, so an error shows within one cycle of the read.

// File: rtl/sps_pkg.sv
// Shared types for the shared-port read steering path.
// Assumes: one word = DATA_W data bits plus one parity bit per byte.
package sps_pkg;
    // Three active-high-forceable steering controls as one bundle
    typedef struct packed {
        logic gate_int_n;
        logic clk_win;
        logic sel_even_n;
    } steer_t;

    // Number of parity bits for a given data width and byte width
    function automatic int par_bits(input int data_w, input int byte_w);
        return data_w / byte_w;
    endfunction
endpackage

// File: rtl/sps_force_ctl.sv
// Add-on forcing of the steering controls.
// Function: ORs the add-on's assert term into each host control during the
// add-on's storage-2/3 cycles and flags when add-on data owns the odd lanes.
// Assumes: only a high level can be imposed (wired-OR bus).
module sps_force_ctl
    import sps_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  steer_t host_ctl,
    input  logic   addon_sel,
    input  logic   stor2,
    input  logic   stor3,
    output steer_t eff_ctl,
    output logic   addon_pick
);
    logic force_hi;

    // Add-on asserts its overrides in both storage phases of its access
    always_comb force_hi = addon_sel & (stor2 | stor3);

    // Wired-OR of host values with the add-on override
    always_comb begin
        eff_ctl.gate_int_n = host_ctl.gate_int_n | force_hi;
        eff_ctl.clk_win    = host_ctl.clk_win    | force_hi;
        eff_ctl.sel_even_n = host_ctl.sel_even_n | force_hi;
    end

    // Port-sharing mux steers add-on data only with all three controls high
    always_comb addon_pick = addon_sel & eff_ctl.gate_int_n & eff_ctl.clk_win & eff_ctl.sel_even_n;

    // R6
    force_all_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addon_sel && (stor2 || stor3)) |-> (eff_ctl == 3'b111));

    // R6
    no_force_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addon_sel |-> (eff_ctl == host_ctl));
endmodule

// File: rtl/sps_capture.sv
// Source selection and doubleword capture register.
// Function: picks internal or external doubleword, substitutes the add-on
// word on the odd lanes when picked, and loads the result under the window.
// Assumes: odd word is the low word, even word is the high word.
module sps_capture #(
    parameter int WORD_W = 36,
    localparam int DW_W  = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW_W-1:0]   int_dw,
    input  logic [DW_W-1:0]   ext_dw,
    input  logic [WORD_W-1:0] addon_odd,
    input  logic              gate_int_n,
    input  logic              clk_win,
    input  logic              addon_pick,
    output logic [DW_W-1:0]   cap_q
);
    logic [DW_W-1:0] cap_d;

    // Per-word source muxes; the odd word gains the port-sharing input
    for (genvar w = 0; w < 2; w++) begin : g_word
        logic [WORD_W-1:0] first_sel;
        // Internal versus external cabinet for this word
        always_comb first_sel = gate_int_n ? ext_dw[w*WORD_W +: WORD_W]
                                           : int_dw[w*WORD_W +: WORD_W];
        if (w == 0) begin : g_odd
            // Odd lanes: add-on word overrides when picked
            always_comb cap_d[WORD_W-1:0] = addon_pick ? addon_odd : first_sel;
        end else begin : g_even
            // Even lanes: no extra stage in this path
            always_comb cap_d[DW_W-1:WORD_W] = first_sel;
        end
    end

    // Capture register, open-window load, synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_q <= '0;
        else if (clk_win) cap_q <= cap_d;
    end

    // R3
    hold_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_win |=> $stable(cap_q));

    // R2
    internal_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_win && !gate_int_n) |=> (cap_q == $past(int_dw)));

    // R2
    external_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_win && gate_int_n) |=> (cap_q[DW_W-1:WORD_W] == $past(ext_dw[DW_W-1:WORD_W])));

    // R7
    addon_odd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_win && addon_pick) |=> (cap_q[WORD_W-1:0] == $past(addon_odd)));
endmodule

// File: rtl/sps_word_sel.sv
// Word select, bus multiplexer and parity check.
// Function: picks even or odd captured word, then chooses it or the ALU
// result for the bus, and checks per-byte even parity of the bus word.
// Assumes: parity bit DATA_W+i covers byte i of the data field.
module sps_word_sel #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int PAR_W  = DATA_W / BYTE_W,
    localparam int WORD_W = DATA_W + PAR_W,
    localparam int DW_W   = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW_W-1:0]   cap_q,
    input  logic              sel_even_n,
    input  logic [WORD_W-1:0] alu_d,
    input  logic              bus_sel_alu,
    output logic [WORD_W-1:0] bus_out,
    output logic              par_err
);
    logic [WORD_W-1:0] half_word;
    logic [PAR_W-1:0]  byte_bad;

    // Even word when the active-low select is low, odd word otherwise
    always_comb half_word = sel_even_n ? cap_q[WORD_W-1:0] : cap_q[DW_W-1:WORD_W];

    // Final bus source: memory word or latched ALU result
    always_comb bus_out = bus_sel_alu ? alu_d : half_word;

    // Per-byte even-parity comparison
    for (genvar b = 0; b < PAR_W; b++) begin : g_par
        always_comb byte_bad[b] = (^bus_out[b*BYTE_W +: BYTE_W]) ^ bus_out[DATA_W + b];
    end

    // Any byte mismatch flags the word
    always_comb par_err = |byte_bad;

    // R5
    alu_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel_alu |-> (bus_out == alu_d));

    // R4
    even_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel_alu && !sel_even_n) |-> (bus_out == cap_q[DW_W-1:WORD_W]));
endmodule

// File: rtl/shared_port_steer.sv
// Top of the shared-port read steering path.
// Function: wires forcing logic, capture stage and word selection together
// and exposes the effective steering controls.
// Assumes: stor2 and stor3 are never high together.
module shared_port_steer #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int PAR_W  = DATA_W / BYTE_W,
    localparam int WORD_W = DATA_W + PAR_W,
    localparam int DW_W   = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW_W-1:0]   int_dw,
    input  logic [DW_W-1:0]   ext_dw,
    input  logic [WORD_W-1:0] addon_odd,
    input  logic [WORD_W-1:0] alu_d,
    input  logic              host_gate_int_n,
    input  logic              host_clk_win,
    input  logic              host_sel_even_n,
    input  logic              addon_sel,
    input  logic              stor2,
    input  logic              stor3,
    input  logic              bus_sel_alu,
    output logic [WORD_W-1:0] bus_out,
    output logic              par_err,
    output logic              gate_int_n_eff,
    output logic              clk_win_eff,
    output logic              sel_even_n_eff
);
    import sps_pkg::*;

    steer_t          host_ctl;
    steer_t          eff_ctl;
    logic            addon_pick;
    logic [DW_W-1:0] cap_q;

    // Bundle host controls
    always_comb host_ctl = '{gate_int_n: host_gate_int_n, clk_win: host_clk_win,
                             sel_even_n: host_sel_even_n};

    sps_force_ctl i_force (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_ctl  (host_ctl),
        .addon_sel (addon_sel),
        .stor2     (stor2),
        .stor3     (stor3),
        .eff_ctl   (eff_ctl),
        .addon_pick(addon_pick)
    );

    sps_capture #(.WORD_W(WORD_W)) i_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .int_dw    (int_dw),
        .ext_dw    (ext_dw),
        .addon_odd (addon_odd),
        .gate_int_n(eff_ctl.gate_int_n),
        .clk_win   (eff_ctl.clk_win),
        .addon_pick(addon_pick),
        .cap_q     (cap_q)
    );

    sps_word_sel #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) i_wsel (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_q      (cap_q),
        .sel_even_n (eff_ctl.sel_even_n),
        .alu_d      (alu_d),
        .bus_sel_alu(bus_sel_alu),
        .bus_out    (bus_out),
        .par_err    (par_err)
    );

    // Expose effective controls
    always_comb begin
        gate_int_n_eff = eff_ctl.gate_int_n;
        clk_win_eff    = eff_ctl.clk_win;
        sel_even_n_eff = eff_ctl.sel_even_n;
    end

    // R10
    stor3_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addon_sel && stor3 && !host_clk_win) |=> (bus_sel_alu || sel_even_n_eff || bus_out == $past(ext_dw[DW_W-1:WORD_W])));
endmodule

// File: tb/test_shared_port_steer.sv
// Scoreboard bench: driver tasks queue expected bus words, a monitor compares.
module test_shared_port_steer;
    localparam int WW = 36;
    localparam int DW = 72;

    typedef struct {
        logic [WW-1:0] bus;
        logic          err;
        string         tag;
    } exp_t;

    logic clk = 0, rst_n = 0;
    logic [DW-1:0] int_dw = '0, ext_dw = '0;
    logic [WW-1:0] addon_odd = '0, alu_d = '0;
    logic host_gate_int_n = 0, host_clk_win = 0, host_sel_even_n = 0;
    logic addon_sel = 0, stor2 = 0, stor3 = 0, bus_sel_alu = 0;
    logic [WW-1:0] bus_out;
    logic par_err, gate_int_n_eff, clk_win_eff, sel_even_n_eff;

    int checks = 0, errors = 0;
    exp_t sb_q[$];
    logic [DW-1:0] m_cap = '0;
    event chk_ev;

    always #2.5 clk = ~clk;

    shared_port_steer i_shared_port_steer (.*);

    function automatic logic [WW-1:0] mkw(input logic [31:0] d);
        logic [3:0] p;
        for (int i = 0; i < 4; i++) p[i] = ^d[8*i +: 8];
        return {p, d};
    endfunction

    function automatic logic exp_err(input logic [WW-1:0] w);
        logic e = 0;
        for (int i = 0; i < 4; i++) e |= (^w[8*i +: 8]) ^ w[32+i];
        return e;
    endfunction

    task automatic check(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one capture cycle and update the reference register
    task automatic cap_cycle(input logic [DW-1:0] i_dw, input logic [DW-1:0] e_dw,
                             input logic [WW-1:0] a_w, input logic g_n, input logic win,
                             input logic s_n, input logic a_sel, input logic s2, input logic s3,
                             input string tag);
        logic f, eg, ew, es;
        @(negedge clk);
        int_dw = i_dw; ext_dw = e_dw; addon_odd = a_w;
        host_gate_int_n = g_n; host_clk_win = win; host_sel_even_n = s_n;
        addon_sel = a_sel; stor2 = s2; stor3 = s3; bus_sel_alu = 0;
        f  = a_sel & (s2 | s3);
        eg = g_n | f; ew = win | f; es = s_n | f;
        #1;
        check({tag, " eff controls"}, {33'd0, gate_int_n_eff, clk_win_eff, sel_even_n_eff},
              {33'd0, eg, ew, es});
        if (ew) begin
            m_cap = eg ? e_dw : i_dw;
            if (a_sel & eg & es) m_cap[WW-1:0] = a_w;
        end
    endtask

    // Read one captured word with forcing off and queue its expectation
    task automatic rd(input logic even, input string tag);
        exp_t e;
        @(negedge clk);
        addon_sel = 0; stor2 = 0; stor3 = 0; host_clk_win = 0;
        host_gate_int_n = 0; host_sel_even_n = ~even; bus_sel_alu = 0;
        e.bus = even ? m_cap[DW-1:WW] : m_cap[WW-1:0];
        e.err = exp_err(e.bus);
        e.tag = tag;
        sb_q.push_back(e);
        -> chk_ev;
    endtask

    // Monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            exp_t e;
            @(chk_ev);
            #1;
            e = sb_q.pop_front();
            check(e.tag, bus_out, e.bus);
            check({e.tag, " par_err"}, {35'd0, par_err}, {35'd0, e.err});
        end
    end

    initial begin
        #200000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [WW-1:0] w0, w1, w2, w3, w4, w5, bad;
        w0 = mkw(32'h1234_5678); w1 = mkw(32'h9ABC_DEF0);
        w2 = mkw(32'hA5A5_0F0F); w3 = mkw(32'h0001_8000);
        w4 = mkw(32'hDEAD_BEEF); w5 = mkw(32'hCAFE_F00D);
        bad = mkw(32'h0000_00FF) ^ 36'h1_0000_0000;

        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R1 reset state on the bus
        check("R1 reset bus", bus_out, '0);
        check("R1 reset par_err", {35'd0, par_err}, 36'd0);
        @(negedge clk); rst_n = 1;

        // R2 internal source, R4 both halves
        cap_cycle({w0, w1}, {w2, w3}, w4, 0, 1, 0, 0, 0, 0, "R2 int");
        rd(1, "R2/R4 int even");
        rd(0, "R2/R4 int odd");
        // R2 external source
        cap_cycle({w0, w1}, {w2, w3}, w4, 1, 1, 1, 0, 0, 0, "R2 ext");
        rd(1, "R2 ext even");
        rd(0, "R2 ext odd");
        // R3 window closed: contents kept
        cap_cycle({w4, w5}, {w5, w4}, w0, 0, 0, 0, 0, 0, 0, "R3 closed");
        rd(1, "R3 hold even");
        rd(0, "R3 hold odd");
        // R6/R7 add-on storage-2 with host controls low
        cap_cycle({w0, w1}, {w3, w2}, w5, 0, 0, 0, 1, 1, 0, "R6 stor2 force");
        rd(1, "R7 addon even from ext");
        rd(0, "R7 addon odd");
        // R10 storage-3 load with host window low
        cap_cycle({w1, w0}, {w4, w3}, w2, 0, 0, 0, 1, 0, 1, "R10 stor3 force");
        rd(1, "R10 stor3 even");
        rd(0, "R10 stor3 odd");
        // R8 add-on not selected, host controls all high
        cap_cycle({w1, w0}, {w5, w1}, w3, 1, 1, 1, 0, 1, 0, "R8 no addon");
        rd(0, "R8 ext odd kept");
        // R6 add-on selected outside storage-2/3: no forcing
        cap_cycle({w2, w3}, {w0, w0}, w4, 0, 1, 0, 1, 0, 0, "R6 addon idle");
        rd(0, "R6 idle int odd");
        // R9 bad parity word on the odd lane
        cap_cycle({w0, bad}, {w2, w3}, w4, 0, 1, 0, 0, 0, 0, "R9 bad");
        rd(0, "R9 bad parity");
        rd(1, "R9 good parity");
        // R5 ALU path with a bad-parity ALU word
        @(negedge clk);
        alu_d = bad; bus_sel_alu = 1;
        #1;
        check("R5 alu bus", bus_out, bad);
        check("R5/R9 alu par_err", {35'd0, par_err}, 36'd1);
        @(negedge clk);
        alu_d = w5;
        #1;
        check("R5 alu bus good", bus_out, w5);
        @(negedge clk);
        bus_sel_alu = 0;
        repeat (2) @(negedge clk);
        if (sb_q.size() != 0) begin
            errors++; checks++;
            $display("FAIL scoreboard: actual=%0d left expected=0", sb_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule